// File: doc/BRIEF.md
# I/O Port Window Decoder for a Disk and Clock Adapter

This block decodes an 8-bit processor I/O address into select strobes for a small adapter that carries a real-time clock, an expansion hook and two IDE devices. The upper four address bits are compared with a 4-bit base value set by board jumpers. When they match, the low four bits pick one target inside the 16-port window. The three IDE register-address lines are a plain copy of the low address bits.

The window is not split evenly. Four offsets belong to nobody, so other peripherals may sit there. One offset drives the expansion select and one drives the clock select. Two offsets drive the IDE control-block chip select and eight drive the IDE command-block chip select. A select only asserts during a genuine I/O read or write cycle. Memory cycles and interrupt acknowledge never produce a select.

The block is purely combinational. Every output follows its inputs with no register in the path.

Top module: `iodec_port_select`

## Requirements
- R1: No select asserts unless address bits 7..4 equal the 4-bit jumper level input.
- R2: A fitted jumper presents level 0 and an absent jumper presents level 1. Address bit 4+k must equal jumper level bit k, so all jumpers fitted selects the window at ports 0x00..0x0F.
- R3: Offsets 0x0..0x3 inside a matching window assert no select.
- R4: Offset 0x4 asserts `exp_sel_n` (low) and no other select.
- R5: Offset 0x5 asserts `rtc_sel_n` (low) and no other select.
- R6: Offsets 0x6 and 0x7 (alternate status/device control, drive address) assert `ide_cs1_n` (low) and no other select.
- R7: Offsets 0x8..0xF (data, error/feature, sector count, sector number, cylinder low, cylinder high, drive/head, command/status) assert `ide_cs0_n` (low) and no other select.
- R8: `ide_reg_addr` always equals address bits 2..0, whether or not a select is active.
- R9: With `iorq_n` high, no select asserts.
- R10: With `iorq_n` and `m1_n` both low (interrupt acknowledge), no select asserts.
- R11: With `iorq_n` low and both `rd_n` and `wr_n` high, no select asserts.
- R12: At most one select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 8 | I/O port address |
| jumper_lvl | input | 4 | Base-address jumper levels (fitted = 0) |
| exp_sel_n | output | 1 | Expansion select, active low |
| rtc_sel_n | output | 1 | Clock select, active low |
| ide_cs0_n | output | 1 | IDE command-block chip select, active low |
| ide_cs1_n | output | 1 | IDE control-block chip select, active low |
| ide_reg_addr | output | 3 | IDE register address |

## Verification
The bench sweeps every port address against every jumper setting, for both read and write cycles. This catches any offset mapped to the wrong target. A design that swapped the two IDE chip selects, or claimed offsets 0..3, would show up at those exact ports. A reversed jumper polarity, or a bit-swapped base comparison, would move the window to the wrong place and produce selects outside it. The interrupt-acknowledge, idle-request and strobe-less cycles are run over the whole window. A decoder that ignored `m1_n` or the strobes would assert a select during those cycles.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

  localparam int NUM_TGT  = 4;
  localparam int IDX_EXP  = 0;
  localparam int IDX_RTC  = 1;
  localparam int IDX_CTRL = 2;
  localparam int IDX_CMD  = 3;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_EXP,
    TGT_RTC,
    TGT_CTRL,
    TGT_CMD
  } tgt_e;

  // Offset classification inside the 16-port window.
  function automatic tgt_e classify(input logic [3:0] ofs);
    if (ofs[3])                return TGT_CMD;
    else if (ofs[2:1] == 2'b11) return TGT_CTRL;
    else if (ofs == 4'h5)      return TGT_RTC;
    else if (ofs == 4'h4)      return TGT_EXP;
    else                       return TGT_NONE;
  endfunction

endpackage

// File: rtl/iodec_window_match.sv
module iodec_window_match #(
  parameter int BASE_W = 4
) (
  input  logic [BASE_W-1:0] addr_hi,
  input  logic [BASE_W-1:0] jumper_lvl,
  output logic              hit
);
  // Jumper levels map straight onto address bits: fitted = 0.
  always_comb begin
    hit = (addr_hi == jumper_lvl);
  end
endmodule

// File: rtl/iodec_cycle_qual.sv
module iodec_cycle_qual (
  input  logic iorq_n,
  input  logic m1_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic io_cycle
);
  logic strobe;

  always_comb begin
    strobe   = ~rd_n | ~wr_n;
    io_cycle = ~iorq_n & m1_n & strobe;
  end
endmodule

// File: rtl/iodec_offset_map.sv
module iodec_offset_map
  import iodec_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic [OFS_W-1:0]   ofs,
  output logic [NUM_TGT-1:0] tgt_hot
);
  tgt_e tgt;

  always_comb begin
    tgt     = classify(ofs[3:0]);
    tgt_hot = '0;
    unique case (tgt)
      TGT_EXP:  tgt_hot[IDX_EXP]  = 1'b1;
      TGT_RTC:  tgt_hot[IDX_RTC]  = 1'b1;
      TGT_CTRL: tgt_hot[IDX_CTRL] = 1'b1;
      TGT_CMD:  tgt_hot[IDX_CMD]  = 1'b1;
      default:  tgt_hot           = '0;
    endcase
  end

  // R7
  always_comb begin
    cmd_ofs_chk: assert (!tgt_hot[IDX_CMD] || ofs[3])
      else $error("command select outside upper half of window");
  end
endmodule

// File: rtl/iodec_port_select.sv
module iodec_port_select
  import iodec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE_W = 4,
  parameter int REG_W  = 3
) (
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] jumper_lvl,
  output logic              exp_sel_n,
  output logic              rtc_sel_n,
  output logic              ide_cs0_n,
  output logic              ide_cs1_n,
  output logic [REG_W-1:0]  ide_reg_addr
);
  localparam int OFS_W = ADDR_W - BASE_W;

  logic               win_hit;
  logic               io_cycle;
  logic               enable;
  logic [NUM_TGT-1:0] tgt_hot;
  logic [NUM_TGT-1:0] sel_hot;
  logic [NUM_TGT-1:0] sel_n_vec;

  iodec_window_match #(.BASE_W(BASE_W)) u_match (
    .addr_hi    (addr[ADDR_W-1:OFS_W]),
    .jumper_lvl (jumper_lvl),
    .hit        (win_hit)
  );

  iodec_cycle_qual u_qual (
    .iorq_n   (iorq_n),
    .m1_n     (m1_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .io_cycle (io_cycle)
  );

  iodec_offset_map #(.OFS_W(OFS_W)) u_map (
    .ofs     (addr[OFS_W-1:0]),
    .tgt_hot (tgt_hot)
  );

  always_comb begin
    enable  = win_hit & io_cycle;
    sel_hot = tgt_hot & {NUM_TGT{enable}};
  end

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_sel
    assign sel_n_vec[i] = ~sel_hot[i];
  end

  assign exp_sel_n    = sel_n_vec[IDX_EXP];
  assign rtc_sel_n    = sel_n_vec[IDX_RTC];
  assign ide_cs1_n    = sel_n_vec[IDX_CTRL];
  assign ide_cs0_n    = sel_n_vec[IDX_CMD];
  assign ide_reg_addr = addr[REG_W-1:0];

  always_comb begin
    // R12
    one_sel_chk: assert ($onehot0(~{exp_sel_n, rtc_sel_n, ide_cs0_n, ide_cs1_n}))
      else $error("more than one select active");
    // R1
    win_sel_chk: assert (&sel_n_vec || (addr[ADDR_W-1:OFS_W] == jumper_lvl))
      else $error("select outside the jumper window");
    // R9
    iorq_sel_chk: assert (&sel_n_vec || !iorq_n)
      else $error("select without I/O request");
    // R10
    ack_sel_chk: assert (&sel_n_vec || m1_n)
      else $error("select during acknowledge cycle");
    // R11
    strobe_sel_chk: assert (&sel_n_vec || !rd_n || !wr_n)
      else $error("select without read or write strobe");
  end
endmodule

// File: tb/test_iodec_port_select.sv
module test_iodec_port_select;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       iorq_n, m1_n, rd_n, wr_n;
  logic [7:0] addr;
  logic [3:0] jumper_lvl;
  logic       exp_sel_n, rtc_sel_n, ide_cs0_n, ide_cs1_n;
  logic [2:0] ide_reg_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  iodec_port_select i_iodec_port_select (
    .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .jumper_lvl(jumper_lvl),
    .exp_sel_n(exp_sel_n), .rtc_sel_n(rtc_sel_n),
    .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
    .ide_reg_addr(ide_reg_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic apply(input logic iq, input logic m1, input logic rd,
                       input logic wr, input logic [7:0] a, input logic [3:0] j);
    @(posedge clk);
    iorq_n = iq; m1_n = m1; rd_n = rd; wr_n = wr; addr = a; jumper_lvl = j;
    @(negedge clk);
  endtask

  task automatic check_now(input string req);
    logic [3:0] exp_v, act_v;
    logic [3:0] ofs;
    logic en;
    ofs = addr[3:0];
    en  = (addr[7:4] == jumper_lvl) && !iorq_n && m1_n && (!rd_n || !wr_n);
    // order: exp, rtc, cs1, cs0 (active high)
    exp_v = 4'b0000;
    if (en) begin
      if (ofs == 4'd4)                       exp_v = 4'b1000;
      else if (ofs == 4'd5)                  exp_v = 4'b0100;
      else if (ofs == 4'd6 || ofs == 4'd7)   exp_v = 4'b0010;
      else if (ofs >= 4'd8)                  exp_v = 4'b0001;
    end
    act_v = ~{exp_sel_n, rtc_sel_n, ide_cs1_n, ide_cs0_n};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s addr=%h jmp=%h sel actual=%b expected=%b",
               req, addr, jumper_lvl, act_v, exp_v);
    end
    checks++;
    if (ide_reg_addr !== addr[2:0]) begin
      fails++;
      $display("FAIL R8 addr=%h reg actual=%h expected=%h",
               addr, ide_reg_addr, addr[2:0]);
    end
    checks++;
    if ($countones(act_v) > 1) begin
      fails++;
      $display("FAIL R12 addr=%h actual=%b expected=at most one", addr, act_v);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a, input logic [3:0] j);
    if (a[7:4] != j)    return "R1";
    if (a[3:0] < 4'd4)  return "R3";
    if (a[3:0] == 4'd4) return "R4";
    if (a[3:0] == 4'd5) return "R5";
    if (a[3:0] < 4'd8)  return "R6";
    return "R7";
  endfunction

  initial begin
    iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = 8'h00; jumper_lvl = 4'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R9 reset idle");

    // R2: all jumpers fitted -> window at 0x00..0x0F
    apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h05, 4'h0);
    check_now("R2 fitted");
    // R2: all jumpers absent -> window at 0xF0..0xFF
    apply(1'b0, 1'b1, 1'b0, 1'b1, 8'hF8, 4'hF);
    check_now("R2 absent");
    apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h18, 4'h8);
    check_now("R2 bit order");

    // Full sweep, read then write cycles: R1 R3 R4 R5 R6 R7 R8 R12
    for (int j = 0; j < 16; j++) begin
      for (int a = 0; a < 256; a++) begin
        apply(1'b0, 1'b1, 1'b0, 1'b1, a[7:0], j[3:0]);
        check_now(tag_of(a[7:0], j[3:0]));
        apply(1'b0, 1'b1, 1'b1, 1'b0, a[7:0], j[3:0]);
        check_now(tag_of(a[7:0], j[3:0]));
      end
    end

    // Control qualification over the matching window for a few jumpers
    for (int j = 0; j < 16; j += 5) begin
      for (int o = 0; o < 16; o++) begin
        apply(1'b1, 1'b1, 1'b0, 1'b1, {j[3:0], o[3:0]}, j[3:0]);
        check_now("R9");
        apply(1'b0, 1'b0, 1'b1, 1'b1, {j[3:0], o[3:0]}, j[3:0]);
        check_now("R10");
        apply(1'b0, 1'b0, 1'b0, 1'b1, {j[3:0], o[3:0]}, j[3:0]);
        check_now("R10");
        apply(1'b0, 1'b1, 1'b1, 1'b1, {j[3:0], o[3:0]}, j[3:0]);
        check_now("R11");
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule